// File: doc/BRIEF.md
# CAN Bit Timer with Phase Resynchronization

This block produces the bit-timing strobes for a CAN controller from the system clock. A programmable divider turns the clock into time-quantum ticks. Each bit time is made of a one-quantum synchronization segment, then a first phase segment that ends at the sample point, then a second phase segment that ends at the transmit point. The bit time in quanta is the sum of the three segments, and the bit rate is its reciprocal.

The receive line is synchronized and checked once per quantum for a recessive-to-dominant transition. When the block is enabled it first waits for such a transition and performs a hard synchronization. While running, the first valid transition in each bit corrects the phase of that bit. A late edge stretches the first segment, and an early edge trims the second segment. The correction is limited to a programmable jump width, and it does not carry over to the next bit. Frame decoding, stuffing, arbitration and error handling belong to the surrounding controller.

Top module: `can_bit_timer`

## Requirements
- R1: While `enable_i` is high, `tq_tick_o` pulses for one clock every `brp_i`+1 clocks (`brp_i` = divide ratio minus one, 0..1023). While `enable_i` is low, it stays low.
- R2: When no edges occur, `sample_o` pulses once per bit. Consecutive pulses are (3 + `seg1_i` + `seg2_i`) quanta apart. `seg1_i` is the first segment length minus one (1..16 quanta) and `seg2_i` is the second segment length minus one (1..8 quanta).
- R3: When no edges occur, `tx_point_o` pulses (`seg2_i`+1) quanta after each `sample_o` pulse.
- R4: At each sample point, `bit_value_o` takes the synchronized receive level (1 = recessive, 0 = dominant) and holds it until the next sample point. It resets to 1.
- R5: While `enable_i` is low, no strobes are produced. After enabling, nothing happens until a 1-to-0 transition of `rx_i`. With a divide ratio of 1, the first `sample_o` is then seen (3 + `seg1_i`) clocks after the `rx_i` change, because of the two-flop synchronizer and the one-quantum sync segment.
- R6: A transition detected in the sync segment causes no adjustment. It still uses up the bit's one valid edge.
- R7: A valid transition detected in quantum j (0-based) of the first segment lengthens that segment by min(j+1, `sjw_i`+1) quanta. `sjw_i` is the jump width minus one (1..4 quanta).
- R8: A valid transition detected in quantum c (0-based) of the second segment shortens it by min(`seg2_i`+1-c, `sjw_i`+1) quanta. If the full error fits within the jump width, the edge quantum becomes the next bit's sync segment, and `tx_point_o` pulses at its tick.
- R9: Only the first 1-to-0 transition in a bit time is used. Later transitions in the same bit have no effect.
- R10: Transitions detected while `tx_dominant_i` is high are not valid edges and cause no adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; low forces idle |
| brp_i | input | 10 | Quantum divide ratio minus one |
| seg1_i | input | 4 | First phase segment length minus one |
| seg2_i | input | 3 | Second phase segment length minus one |
| sjw_i | input | 2 | Resynchronization jump width minus one |
| rx_i | input | 1 | Raw receive line (1 = recessive) |
| tx_dominant_i | input | 1 | Controller is driving a dominant level |
| tq_tick_o | output | 1 | One-clock pulse per time quantum |
| sample_o | output | 1 | Sample point strobe |
| bit_value_o | output | 1 | Level captured at the last sample point |
| tx_point_o | output | 1 | Transmit point strobe |

## Verification
Nominal timing is exercised with a table of divider and segment settings, from the shortest three-quantum bit to the largest divide ratio. Each setting is judged only on the clock distance between strobes, which separates errors in the divider from errors in segment length. Single edges are then placed in the sync segment, early and late in the first segment, and early and late in the second segment. Under two jump widths, these placements separate an uncapped correction from a capped one, and a trimmed second segment from an absorbed one. Double edges and edges that arrive while the controller drives dominant show whether edge qualification works, because each yields a bit length different from the one a miscounted edge would produce.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_SEG1 = 2'd2,
    ST_SEG2 = 2'd3
  } bt_state_e;
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tick_o
);
  logic [BRP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = enable_i && (cnt_q >= brp_i);
    cnt_d  = cnt_q;
    if (!enable_i) begin
      cnt_d = '0;
    end else if (tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + BRP_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R1: with a divide ratio above one, ticks never come back to back
  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && brp_i != '0) |=> (!tick_o || !$stable(brp_i)));
endmodule

// File: rtl/can_bt_rx_edge.sv
module can_bt_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic tick_i,
  input  logic rx_i,
  output logic rx_sync_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;
  logic prev_d;

  always_comb begin
    prev_d = prev_q;
    if (!enable_i || tick_i) prev_d = sync_q;
    fall_o    = tick_i && prev_q && !sync_q;
    rx_sync_o = sync_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_i;
      sync_q <= meta_q;
      prev_q <= prev_d;
    end
  end

  // R9: a detected transition is consumed; the stored level follows it
  assert_fall_consumed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !prev_q);
endmodule

// File: rtl/can_bt_seg_fsm.sv
module can_bt_seg_fsm
  import can_bt_pkg::*;
#(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              tick_i,
  input  logic              fall_i,
  input  logic              rx_sync_i,
  input  logic              tx_dom_i,
  input  logic [SEG1_W-1:0] seg1_i,
  input  logic [SEG2_W-1:0] seg2_i,
  input  logic [SJW_W-1:0]  sjw_i,
  output logic              sample_o,
  output logic              tx_point_o,
  output logic              bit_o
);
  localparam int CNT_W = SEG1_W + 1;
  localparam int EXT_W = SJW_W + 1;

  bt_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] ext_q, ext_d;
  logic [EXT_W-1:0] shr_q, shr_d;
  logic             seen_q, seen_d;
  logic             bit_q, bit_d;

  logic             edge_ok;
  logic [CNT_W-1:0] jump_len, lag, ext_cand, ext_use, seg1_end;
  logic [CNT_W-1:0] seg2_last, lead, shr_use;

  always_comb begin
    edge_ok   = fall_i && !seen_q && !tx_dom_i;
    jump_len  = CNT_W'(sjw_i) + CNT_W'(1);
    lag       = cnt_q + CNT_W'(1);
    ext_cand  = (lag < jump_len) ? lag : jump_len;
    ext_use   = edge_ok ? ext_cand : CNT_W'(ext_q);
    seg1_end  = CNT_W'(seg1_i) + ext_use;
    seg2_last = CNT_W'(seg2_i);
    lead      = seg2_last + CNT_W'(1) - cnt_q;
    shr_use   = edge_ok ? jump_len : CNT_W'(shr_q);
  end

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    ext_d      = ext_q;
    shr_d      = shr_q;
    seen_d     = seen_q;
    bit_d      = bit_q;
    sample_o   = 1'b0;
    tx_point_o = 1'b0;
    if (!enable_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      ext_d   = '0;
      shr_d   = '0;
      seen_d  = 1'b0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (fall_i) begin
            state_d = ST_SEG1;
            cnt_d   = '0;
            seen_d  = 1'b1;
            ext_d   = '0;
            shr_d   = '0;
          end
        end
        ST_SYNC: begin
          state_d = ST_SEG1;
          cnt_d   = '0;
          if (edge_ok) seen_d = 1'b1;
        end
        ST_SEG1: begin
          if (edge_ok) seen_d = 1'b1;
          ext_d = EXT_W'(ext_use);
          if (cnt_q == seg1_end) begin
            sample_o = 1'b1;
            bit_d    = rx_sync_i;
            state_d  = ST_SEG2;
            cnt_d    = '0;
            shr_d    = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_SEG2: begin
          if (edge_ok && lead <= jump_len) begin
            tx_point_o = 1'b1;
            state_d    = ST_SEG1;
            cnt_d      = '0;
            seen_d     = 1'b1;
            ext_d      = '0;
            shr_d      = '0;
          end else begin
            if (edge_ok) begin
              seen_d = 1'b1;
              shr_d  = EXT_W'(shr_use);
            end
            if (cnt_q + shr_use == seg2_last) begin
              tx_point_o = 1'b1;
              state_d    = ST_SYNC;
              cnt_d      = '0;
              seen_d     = 1'b0;
              ext_d      = '0;
              shr_d      = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ext_q   <= '0;
      shr_q   <= '0;
      seen_q  <= 1'b0;
      bit_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ext_q   <= ext_d;
      shr_q   <= shr_d;
      seen_q  <= seen_d;
      bit_q   <= bit_d;
    end
  end

  assign bit_o = bit_q;

  // R2: every sample point starts the second segment from its first quantum
  assert_sample_opens_seg2_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> (state_q == ST_SEG2 && cnt_q == '0));

  // R5: dropping the enable always lands in idle
  assert_disable_idles_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (state_q == ST_IDLE));

  // R7: the first segment never runs past its length plus the jump width
  assert_seg1_bounded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEG1) |-> (cnt_q <= CNT_W'(seg1_i) + jump_len));

  // R8: the second segment is never trimmed by more than the jump width
  assert_seg2_trim_capped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEG2) |-> (CNT_W'(shr_q) <= jump_len));

  // R9: once the bit's edge is used, the lengthening stays frozen
  assert_ext_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEG1 && seen_q && enable_i) |=> (ext_q == $past(ext_q)));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W  = 10,
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [BRP_W-1:0]  brp_i,
  input  logic [SEG1_W-1:0] seg1_i,
  input  logic [SEG2_W-1:0] seg2_i,
  input  logic [SJW_W-1:0]  sjw_i,
  input  logic              rx_i,
  input  logic              tx_dominant_i,
  output logic              tq_tick_o,
  output logic              sample_o,
  output logic              bit_value_o,
  output logic              tx_point_o
);
  logic tick;
  logic rx_sync;
  logic fall;

  can_bt_prescaler #(.BRP_W(BRP_W)) u_prescaler (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .brp_i   (brp_i),
    .tick_o  (tick)
  );

  can_bt_rx_edge u_rx_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .tick_i   (tick),
    .rx_i     (rx_i),
    .rx_sync_o(rx_sync),
    .fall_o   (fall)
  );

  can_bt_seg_fsm #(
    .SEG1_W(SEG1_W),
    .SEG2_W(SEG2_W),
    .SJW_W (SJW_W)
  ) u_seg_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .tick_i    (tick),
    .fall_i    (fall),
    .rx_sync_i (rx_sync),
    .tx_dom_i  (tx_dominant_i),
    .seg1_i    (seg1_i),
    .seg2_i    (seg2_i),
    .sjw_i     (sjw_i),
    .sample_o  (sample_o),
    .tx_point_o(tx_point_o),
    .bit_o     (bit_value_o)
  );

  assign tq_tick_o = tick;
endmodule

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [9:0] brp;
  logic [3:0] seg1;
  logic [2:0] seg2;
  logic [1:0] sjw;
  logic       rx;
  logic       tx_dom;
  logic       tq_tick, sample, bit_value, tx_point;

  always #2 clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .brp_i(brp),
    .seg1_i(seg1), .seg2_i(seg2), .sjw_i(sjw), .rx_i(rx),
    .tx_dominant_i(tx_dom), .tq_tick_o(tq_tick), .sample_o(sample),
    .bit_value_o(bit_value), .tx_point_o(tx_point)
  );

  typedef struct packed {
    logic [9:0]  brp;
    logic [3:0]  s1;
    logic [2:0]  s2;
    logic [31:0] e_tick;
    logic [31:0] e_bit;
    logic [31:0] e_tx;
  } vec_t;

  // divider, segment codes, expected tick gap, bit length and sample-to-tx, in clocks
  localparam vec_t VECS [6] = '{
    '{10'd0,    4'd3,  3'd1, 32'd1,    32'd7,    32'd2},
    '{10'd2,    4'd5,  3'd2, 32'd3,    32'd30,   32'd9},
    '{10'd0,    4'd15, 3'd7, 32'd1,    32'd25,   32'd8},
    '{10'd0,    4'd0,  3'd0, 32'd1,    32'd3,    32'd1},
    '{10'd9,    4'd7,  3'd3, 32'd10,   32'd130,  32'd40},
    '{10'd1023, 4'd0,  3'd0, 32'd1024, 32'd3072, 32'd1024}
  };

  int  total = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_sample(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sample && n < 8000);
  endtask

  task automatic measure(output int txn, output int smpn, output int bv1);
    int n = 0;
    txn = 0;
    bv1 = -1;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) bv1 = int'(bit_value);
      if (tx_point && txn == 0) txn = n;
    end while (!sample && n < 8000);
    smpn = n;
  endtask

  // start at a sample strobe; drive rx low at step k, high at kup, low at kdn
  task automatic resync(input int k, input int kup, input int kdn, input logic txd,
                        output int txn, output int smpn);
    int n = 0;
    int d;
    txn = 0;
    tx_dom = txd;
    if (k == 0) rx = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (tx_point && txn == 0) txn = n;
      if (!sample) begin
        if (n == k)   rx = 1'b0;
        if (n == kup) rx = 1'b1;
        if (n == kdn) rx = 1'b0;
      end
    end while (!sample && n < 8000);
    smpn = n;
    rx = 1'b1;
    tx_dom = 1'b0;
    wait_sample(d);
    wait_sample(d);
  endtask

  task automatic hard_start(input logic [1:0] jw);
    int d;
    enable = 1'b0;
    rx = 1'b1;
    repeat (2) @(negedge clk);
    brp = 10'd0; seg1 = 4'd7; seg2 = 3'd3; sjw = jw;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    rx = 1'b0;
    wait_sample(d);
    rx = 1'b1;
    wait_sample(d);
    wait_sample(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n, txn, smpn, bv1, quiet;
    rst_n = 1'b0; enable = 1'b0; rx = 1'b1; tx_dom = 1'b0;
    brp = '0; seg1 = '0; seg2 = '0; sjw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 reset tick", int'(tq_tick), 0);
    check_eq("R5 reset strobes", int'(sample | tx_point), 0);
    check_eq("R4 reset bit value", int'(bit_value), 1);

    for (int v = 0; v < 6; v++) begin
      enable = 1'b0;
      rx = 1'b1;
      repeat (2) @(negedge clk);
      brp = VECS[v].brp; seg1 = VECS[v].s1; seg2 = VECS[v].s2; sjw = 2'd0;
      quiet = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        quiet += int'(sample | tx_point | tq_tick);
      end
      check_eq("R5 disabled silent", quiet, 0);
      enable = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!tq_tick && n < 4000);
      n = 0;
      do begin @(negedge clk); n++; end while (!tq_tick && n < 4000);
      check_eq("R1 tick gap", n, int'(VECS[v].e_tick));
      quiet = 0;
      for (int i = 0; i < int'(VECS[v].e_bit) * 2; i++) begin
        @(negedge clk);
        quiet += int'(sample | tx_point);
      end
      check_eq("R5 waits for edge", quiet, 0);
      rx = 1'b0;
      wait_sample(n);
      if (VECS[v].brp == 10'd0) check_eq("R5 hard sync delay", n, 3 + int'(VECS[v].s1));
      rx = 1'b1;
      measure(txn, smpn, bv1);
      check_eq("R4 dominant sampled", bv1, 0);
      check_eq("R3 tx after sample", txn, int'(VECS[v].e_tx));
      check_eq("R2 bit length", smpn, int'(VECS[v].e_bit));
      @(negedge clk);
      check_eq("R4 recessive sampled", int'(bit_value), 1);
    end

    // resync: seg1 = 8, seg2 = 4, nominal bit 13 clocks, jump width 2
    hard_start(2'd1);
    resync(-1, -1, -1, 1'b0, txn, smpn);
    check_eq("R2 no edge", smpn, 13);
    resync(3, -1, -1, 1'b0, txn, smpn);
    check_eq("R6 edge in sync seg", smpn, 13);
    resync(4, -1, -1, 1'b0, txn, smpn);
    check_eq("R7 lengthen by 1", smpn, 14);
    resync(9, -1, -1, 1'b0, txn, smpn);
    check_eq("R7 lengthen capped", smpn, 15);
    resync(2, -1, -1, 1'b0, txn, smpn);
    check_eq("R8 absorbed edge sample", smpn, 12);
    check_eq("R8 absorbed edge tx", txn, 4);
    resync(0, -1, -1, 1'b0, txn, smpn);
    check_eq("R8 trim capped sample", smpn, 11);
    check_eq("R8 trim capped tx", txn, 2);
    resync(4, 6, 8, 1'b0, txn, smpn);
    check_eq("R9 second edge ignored", smpn, 14);
    resync(4, -1, -1, 1'b1, txn, smpn);
    check_eq("R10 own dominant ignored", smpn, 13);

    // jump width 4
    hard_start(2'd3);
    resync(9, -1, -1, 1'b0, txn, smpn);
    check_eq("R7 lengthen wide jump", smpn, 17);
    resync(0, -1, -1, 1'b0, txn, smpn);
    check_eq("R8 absorbed wide jump", smpn, 10);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule